// File: doc/BRIEF.md
# Seven-Product 2x2 Block Dot-Product Combiner

This block multiplies a 2x2 block matrix of weights W by a 2x2 block matrix of inputs X. Each block element is a vector of K signed samples, and "multiplying" two elements means taking their K-tap dot product. That dot product stands in for one small sub-convolution. A direct evaluation needs eight such dot products. This block needs only seven. It forms sums and differences of the blocks first, runs the seven shared dot products, and then recombines them into the four output blocks Y11, Y12, Y21 and Y22. Every result is exact: all intermediate widths grow far enough that no sum, difference or product can wrap.

A source offers one complete operand set per transfer on a valid/ready handshake. The operands pass through three register stages: pre-add, dot product and post-add. The four results are then offered on a second valid/ready handshake. While the consumer holds back, the whole pipeline freezes, so no operand set is dropped or repeated. Results leave in the order in which their operands were accepted.

Top module: `strassen_combiner`

## Requirements
- R1: `in_ready` is high whenever `out_valid` is low or `out_ready` is high, and it is low while `out_valid` is high and `out_ready` is low.
- R2: Sample k of block b is at bits `[(b*K+k)*WW +: WW]` of `in_w` and at `[(b*K+k)*DW +: DW]` of `in_x`, with b = 0 for 11, 1 for 12, 2 for 21 and 3 for 22. Output block b is at `[b*YW +: YW]` of `out_y`, two's complement. `out_y` block 0 equals W11·X11 + W12·X21.
- R3: `out_y` block 1 equals W11·X12 + W12·X22.
- R4: `out_y` block 2 equals W21·X11 + W22·X21.
- R5: `out_y` block 3 equals W21·X12 + W22·X22.
- R6: When the output is not stalled, an operand set accepted at a clock edge shows its result with `out_valid` high after the third rising edge, counting the accepting edge as the first.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_y` does not change.
- R8: Each accepted operand set produces exactly one result, and results are delivered in acceptance order.
- R9: After reset, `out_valid` is low and `in_ready` is high.
- R10: The results are exact at the extreme signed sample values, with every sample at its most negative or its most positive value. `YW` is `WW+DW+$clog2(K)+4`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand set offered |
| in_ready | output | 1 | Operand set can be taken this cycle |
| in_w | input | 4*K*WW | Four weight blocks of K signed samples |
| in_x | input | 4*K*DW | Four input blocks of K signed samples |
| out_valid | output | 1 | Result set offered |
| out_ready | input | 1 | Consumer takes the result set |
| out_y | output | 4*YW | Four signed result blocks |

## Verification
A result is due after the third rising edge, counting the edge that accepts its operands, and only if `out_ready` stays high. The bench drives its inputs just after each falling edge and samples 2 ns later. With that timing, the latency check expects `out_valid` at the third falling-edge sample after the accepting one. A scoreboard queue pairs each accepted operand set with the result set that later leaves, so the order is checked without any fixed cycle count. During a forced stall, the bench takes a snapshot of `out_y` and compares each following sample against it. It also confirms that an operand set offered during the stall is held back until the stall ends.

// File: rtl/strassen_pkg.sv
`timescale 1ns/1ps
package strassen_pkg;

  // number of blocks per operand matrix and number of shared products
  localparam int NBLK  = 4;
  localparam int NPROD = 7;

  // block positions inside a flattened operand or result vector
  typedef enum logic [1:0] {
    BLK_11 = 2'd0,
    BLK_12 = 2'd1,
    BLK_21 = 2'd2,
    BLK_22 = 2'd3
  } blk_pos_e;

  // width of one dot product of two pre-added vectors
  function automatic int prod_width(int dw, int ww, int k);
    return (dw + 1) + (ww + 1) + $clog2(k);
  endfunction

  // width of a recombined result (up to four terms)
  function automatic int res_width(int dw, int ww, int k);
    return prod_width(dw, ww, k) + 2;
  endfunction

endpackage

// File: rtl/sc_preadd.sv
`timescale 1ns/1ps
// Forms the seven (weight, input) operand vectors from the four blocks.
module sc_preadd #(
  parameter int K  = 4,
  parameter int DW = 8,
  parameter int WW = 8,
  localparam int PW = WW + 1,
  localparam int PX = DW + 1
) (
  input  logic [4*K*WW-1:0] w_blk,
  input  logic [4*K*DW-1:0] x_blk,
  output logic [7*K*PW-1:0] pa_w,
  output logic [7*K*PX-1:0] pa_x
);
  import strassen_pkg::*;

  function automatic logic signed [PW-1:0] wext(input logic [WW-1:0] v);
    return {v[WW-1], v};
  endfunction

  function automatic logic signed [PX-1:0] xext(input logic [DW-1:0] v);
    return {v[DW-1], v};
  endfunction

  for (genvar k = 0; k < K; k++) begin : g_tap
    logic signed [PW-1:0] w11, w12, w21, w22;
    logic signed [PX-1:0] x11, x12, x21, x22;

    assign w11 = wext(w_blk[(int'(BLK_11)*K+k)*WW +: WW]);
    assign w12 = wext(w_blk[(int'(BLK_12)*K+k)*WW +: WW]);
    assign w21 = wext(w_blk[(int'(BLK_21)*K+k)*WW +: WW]);
    assign w22 = wext(w_blk[(int'(BLK_22)*K+k)*WW +: WW]);
    assign x11 = xext(x_blk[(int'(BLK_11)*K+k)*DW +: DW]);
    assign x12 = xext(x_blk[(int'(BLK_12)*K+k)*DW +: DW]);
    assign x21 = xext(x_blk[(int'(BLK_21)*K+k)*DW +: DW]);
    assign x22 = xext(x_blk[(int'(BLK_22)*K+k)*DW +: DW]);

    // product 1: (W11+W22)(X11+X22)
    assign pa_w[(0*K+k)*PW +: PW] = w11 + w22;
    assign pa_x[(0*K+k)*PX +: PX] = x11 + x22;
    // product 2: (W21+W22) X11
    assign pa_w[(1*K+k)*PW +: PW] = w21 + w22;
    assign pa_x[(1*K+k)*PX +: PX] = x11;
    // product 3: W11 (X12-X22)
    assign pa_w[(2*K+k)*PW +: PW] = w11;
    assign pa_x[(2*K+k)*PX +: PX] = x12 - x22;
    // product 4: W22 (X21-X11)
    assign pa_w[(3*K+k)*PW +: PW] = w22;
    assign pa_x[(3*K+k)*PX +: PX] = x21 - x11;
    // product 5: (W11+W12) X22
    assign pa_w[(4*K+k)*PW +: PW] = w11 + w12;
    assign pa_x[(4*K+k)*PX +: PX] = x22;
    // product 6: (W21-W11)(X11+X12)
    assign pa_w[(5*K+k)*PW +: PW] = w21 - w11;
    assign pa_x[(5*K+k)*PX +: PX] = x11 + x12;
    // product 7: (W12-W22)(X21+X22)
    assign pa_w[(6*K+k)*PW +: PW] = w12 - w22;
    assign pa_x[(6*K+k)*PX +: PX] = x21 + x22;
  end

endmodule

// File: rtl/sc_dot.sv
`timescale 1ns/1ps
// One K-tap signed dot product of pre-added operand vectors.
module sc_dot #(
  parameter int K  = 4,
  parameter int PW = 9,
  parameter int PX = 9,
  localparam int MW = PW + PX + $clog2(K)
) (
  input  logic [K*PW-1:0]        w_vec,
  input  logic [K*PX-1:0]        x_vec,
  output logic signed [MW-1:0]   m
);

  function automatic logic signed [MW-1:0] dot(input logic [K*PW-1:0] wv,
                                               input logic [K*PX-1:0] xv);
    logic signed [MW-1:0] acc;
    logic signed [PW-1:0] ws;
    logic signed [PX-1:0] xs;
    logic signed [MW-1:0] a;
    logic signed [MW-1:0] b;
    acc = '0;
    for (int k = 0; k < K; k++) begin
      ws  = wv[k*PW +: PW];
      xs  = xv[k*PX +: PX];
      a   = ws;
      b   = xs;
      acc = acc + a * b;
    end
    return acc;
  endfunction

  assign m = dot(w_vec, x_vec);

endmodule

// File: rtl/sc_postadd.sv
`timescale 1ns/1ps
// Recombines the seven products into the four result blocks.
module sc_postadd #(
  parameter int MW = 20,
  localparam int YW = MW + 2
) (
  input  logic [7*MW-1:0] m_all,
  output logic [4*YW-1:0] y_all
);

  function automatic logic signed [YW-1:0] ext(input logic [MW-1:0] v);
    return {{2{v[MW-1]}}, v};
  endfunction

  logic signed [YW-1:0] p [7];

  for (genvar i = 0; i < 7; i++) begin : g_ext
    assign p[i] = ext(m_all[i*MW +: MW]);
  end

  // block 11: P1 + P4 - P5 + P7
  assign y_all[0*YW +: YW] = p[0] + p[3] - p[4] + p[6];
  // block 12: P3 + P5
  assign y_all[1*YW +: YW] = p[2] + p[4];
  // block 21: P2 + P4
  assign y_all[2*YW +: YW] = p[1] + p[3];
  // block 22: P1 - P2 + P3 + P6
  assign y_all[3*YW +: YW] = p[0] - p[1] + p[2] + p[5];

endmodule

// File: rtl/strassen_combiner.sv
`timescale 1ns/1ps
module strassen_combiner #(
  parameter int K  = 4,
  parameter int DW = 8,
  parameter int WW = 8,
  localparam int YW = strassen_pkg::res_width(DW, WW, K)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [4*K*WW-1:0] in_w,
  input  logic [4*K*DW-1:0] in_x,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [4*YW-1:0]   out_y
);
  import strassen_pkg::*;

  localparam int PW = WW + 1;
  localparam int PX = DW + 1;
  localparam int MW = prod_width(DW, WW, K);

  // named pipeline events
  logic advance;
  logic accept;
  logic s1_valid;
  logic s2_valid;

  assign advance  = !out_valid || out_ready;
  assign in_ready = advance;
  assign accept   = in_valid && advance;

  // stage 1: pre-add
  logic [NPROD*K*PW-1:0] pa_w_d, pa_w_q;
  logic [NPROD*K*PX-1:0] pa_x_d, pa_x_q;

  sc_preadd #(.K(K), .DW(DW), .WW(WW)) u_pre (
    .w_blk(in_w),
    .x_blk(in_x),
    .pa_w (pa_w_d),
    .pa_x (pa_x_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s1_valid <= 1'b0;
    else if (advance) s1_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      pa_w_q <= pa_w_d;
      pa_x_q <= pa_x_d;
    end
  end

  // stage 2: seven shared dot products
  logic [NPROD*MW-1:0] m_d, m_q;

  for (genvar p = 0; p < NPROD; p++) begin : g_prod
    sc_dot #(.K(K), .PW(PW), .PX(PX)) u_dot (
      .w_vec(pa_w_q[p*K*PW +: K*PW]),
      .x_vec(pa_x_q[p*K*PX +: K*PX]),
      .m    (m_d[p*MW +: MW])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s2_valid <= 1'b0;
    else if (advance) s2_valid <= s1_valid;
  end

  always_ff @(posedge clk) begin
    if (advance && s1_valid) m_q <= m_d;
  end

  // stage 3: post-add
  logic [4*YW-1:0] y_d;

  sc_postadd #(.MW(MW)) u_post (
    .m_all(m_q),
    .y_all(y_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else if (advance) out_valid <= s2_valid;
  end

  always_ff @(posedge clk) begin
    if (advance && s2_valid) out_y <= y_d;
  end

endmodule

// File: rtl/strassen_combiner_chk.sv
`timescale 1ns/1ps
module strassen_combiner_chk #(
  parameter int OW = 88
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [OW-1:0] out_y,
  input logic          advance,
  input logic          s1_valid,
  input logic          s2_valid
);

  // R1
  ready_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  // R1
  block_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R7
  hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_y)));

  // R6
  take_to_s1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> s1_valid);

  // R6
  s1_to_s2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && advance) |=> s2_valid);

  // R6
  s2_to_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_valid && advance) |=> out_valid);

  // R8
  no_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!advance && s1_valid) |=> s1_valid);

endmodule

bind strassen_combiner strassen_combiner_chk #(.OW(4*YW)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_y    (out_y),
  .advance  (advance),
  .s1_valid (s1_valid),
  .s2_valid (s2_valid)
);

// File: tb/strassen_combiner_tb.sv
`timescale 1ns/1ps
module strassen_combiner_tb_top;

  localparam int K  = 4;
  localparam int DW = 8;
  localparam int WW = 8;
  localparam int YW = WW + DW + $clog2(K) + 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [4*K*WW-1:0] in_w = '0;
  logic [4*K*DW-1:0] in_x = '0;
  logic              out_valid;
  logic              out_ready = 1'b0;
  logic [4*YW-1:0]   out_y;

  always #10 clk = ~clk;  // 50 MHz

  strassen_combiner #(.K(K), .DW(DW), .WW(WW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_w(in_w), .in_x(in_x),
    .out_valid(out_valid), .out_ready(out_ready), .out_y(out_y)
  );

  int checks = 0;
  int errors = 0;
  int sent = 0;
  int recv = 0;
  bit done = 1'b0;
  bit took;
  bit gave;
  logic [4*YW-1:0] expq [$];

  // direct eight-product reference
  function automatic longint dotb(input logic [4*K*WW-1:0] w,
                                  input logic [4*K*DW-1:0] x,
                                  input int wb, input int xb);
    longint s = 0;
    for (int k = 0; k < K; k++)
      s += longint'($signed(w[(wb*K+k)*WW +: WW])) *
           longint'($signed(x[(xb*K+k)*DW +: DW]));
    return s;
  endfunction

  function automatic logic [4*YW-1:0] ref_y(input logic [4*K*WW-1:0] w,
                                            input logic [4*K*DW-1:0] x);
    logic [4*YW-1:0] r;
    r[0*YW +: YW] = YW'(dotb(w, x, 0, 0) + dotb(w, x, 1, 2));
    r[1*YW +: YW] = YW'(dotb(w, x, 0, 1) + dotb(w, x, 1, 3));
    r[2*YW +: YW] = YW'(dotb(w, x, 2, 0) + dotb(w, x, 3, 2));
    r[3*YW +: YW] = YW'(dotb(w, x, 2, 1) + dotb(w, x, 3, 3));
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one cycle: drive after falling edge, sample 2 ns later
  task automatic cycle(input bit v, input logic [4*K*WW-1:0] w,
                       input logic [4*K*DW-1:0] x, input bit rdy);
    logic [4*YW-1:0] e;
    @(negedge clk);
    in_valid  = v;
    in_w      = w;
    in_x      = x;
    out_ready = rdy;
    #2;
    took = in_valid && in_ready;
    gave = out_valid && out_ready;
    if (took) begin
      expq.push_back(ref_y(w, x));
      sent++;
    end
    if (gave) begin
      recv++;
      if (expq.size() == 0) begin
        check(1'b0, "R8 extra result", recv, sent);
      end else begin
        e = expq.pop_front();
        check(out_y[0*YW +: YW] == e[0*YW +: YW], "R2 Y11",
              longint'($signed(out_y[0*YW +: YW])), longint'($signed(e[0*YW +: YW])));
        check(out_y[1*YW +: YW] == e[1*YW +: YW], "R3 Y12",
              longint'($signed(out_y[1*YW +: YW])), longint'($signed(e[1*YW +: YW])));
        check(out_y[2*YW +: YW] == e[2*YW +: YW], "R4 Y21",
              longint'($signed(out_y[2*YW +: YW])), longint'($signed(e[2*YW +: YW])));
        check(out_y[3*YW +: YW] == e[3*YW +: YW], "R5 Y22",
              longint'($signed(out_y[3*YW +: YW])), longint'($signed(e[3*YW +: YW])));
      end
    end
  endtask

  task automatic send(input logic [4*K*WW-1:0] w, input logic [4*K*DW-1:0] x);
    took = 1'b0;
    while (!took) cycle(1'b1, w, x, 1'b1);
  endtask

  task automatic drain();
    for (int i = 0; i < 8; i++) cycle(1'b0, '0, '0, 1'b1);
  endtask

  function automatic logic [4*K*WW-1:0] rnd_w();
    logic [4*K*WW-1:0] r;
    for (int i = 0; i < 4*K; i++) r[i*WW +: WW] = WW'($urandom);
    return r;
  endfunction

  function automatic logic [4*K*DW-1:0] rnd_x();
    logic [4*K*DW-1:0] r;
    for (int i = 0; i < 4*K; i++) r[i*DW +: DW] = DW'($urandom);
    return r;
  endfunction

  // watchdog
  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", recv, sent);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [4*K*WW-1:0] pw;
    logic [4*K*DW-1:0] px;
    logic [4*YW-1:0]   snap;
    bit have;
    int lat;
    void'($urandom(32'd20240611));

    repeat (3) @(negedge clk);
    #2;
    // R9 reset state
    check(out_valid == 1'b0, "R9 out_valid", out_valid, 0);
    check(in_ready == 1'b1, "R9 in_ready", in_ready, 1);
    @(negedge clk);
    rst_n = 1'b1;

    // R10 extreme signed values
    send({(4*K){WW'(1) << (WW-1)}}, {(4*K){DW'(1) << (DW-1)}});
    send({(4*K){~(WW'(1) << (WW-1))}}, {(4*K){DW'(1) << (DW-1)}});
    send({(4*K){~(WW'(1) << (WW-1))}}, {(4*K){~(DW'(1) << (DW-1))}});
    send({(2*K){WW'(1) << (WW-1), ~(WW'(1) << (WW-1))}},
         {(2*K){~(DW'(1) << (DW-1)), DW'(1) << (DW-1)}});
    drain();
    check(recv == 4, "R10 extreme results delivered", recv, 4);

    // R6 latency on an empty, unstalled pipeline
    send(rnd_w(), rnd_x());
    lat = 0;
    for (int n = 1; n <= 6; n++) begin
      cycle(1'b0, '0, '0, 1'b1);
      if (lat == 0 && out_valid) lat = n;
    end
    check(lat == 3, "R6 latency", lat, 3);

    // R7/R1 stall: hold the result, block a new operand set
    pw = rnd_w(); px = rnd_x();
    cycle(1'b1, pw, px, 1'b0);
    for (int n = 0; n < 4; n++) cycle(1'b0, '0, '0, 1'b0);
    check(out_valid == 1'b1, "R7 valid under stall", out_valid, 1);
    snap = out_y;
    pw = rnd_w(); px = rnd_x();
    for (int n = 0; n < 5; n++) begin
      cycle(1'b1, pw, px, 1'b0);
      check(out_valid == 1'b1, "R7 valid held", out_valid, 1);
      check(out_y == snap, "R7 out_y held",
            longint'($signed(out_y[0+:YW])), longint'($signed(snap[0+:YW])));
      check(took == 1'b0, "R1 in_ready low in stall", took, 0);
    end
    took = 1'b0;
    while (!took) cycle(1'b1, pw, px, 1'b1);
    drain();

    // random traffic with random back-pressure
    have = 1'b0;
    for (int n = 0; n < 3000; n++) begin
      if (!have && ($urandom % 10) < 7) begin
        pw = rnd_w(); px = rnd_x(); have = 1'b1;
      end
      cycle(have, pw, px, ($urandom % 10) < 6);
      if (took) have = 1'b0;
    end
    drain();

    // R8 one result per accepted set
    check(recv == sent && expq.size() == 0, "R8 count", recv, sent);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule